// File: doc/BRIEF.md
# Four-Channel DMA Burst Sequencer

This block is the transfer engine behind four DMA channels. Each channel is loaded with a source address, a target address, a unit count, a unit size (halfword or word) and a step mode for each address. While any channel has units left, the sequencer runs a DMA run. It grants the lowest-numbered channel that has units left, moves one unit with a read access and then a write access, and arbitrates again after every unit. Each bus access is tagged sequential or non-sequential according to a burst flag. The flag is set by any access to the program-memory window (0x0800_0000 to 0x0DFF_FFFF). It is cleared when the granted channel changes and when a run ends.

Any address below 0x0200_0000 is protected. The sequencer never puts it on the bus and spends an idle cycle in place of that access. A run opens with one idle cycle and closes with one idle cycle. The bus is a single-cycle interface: read data is taken in the same cycle as the read request.

The state machine has five states. `ST_IDLE` waits for work. `ST_LEAD` is the opening idle cycle. `ST_READ` is the source access. `ST_WRITE` is the target access. `ST_TAIL` is the closing idle cycle. The transitions are:
- `ST_IDLE`→`ST_LEAD` when a channel has units left.
- `ST_LEAD`→`ST_READ` when a channel is granted.
- `ST_READ`→`ST_WRITE` always.
- `ST_WRITE`→`ST_READ` when another unit is pending.
- `ST_WRITE`→`ST_TAIL` when no unit is pending.
- `ST_LEAD`→`ST_TAIL` when no channel is pending.
- `ST_TAIL`→`ST_IDLE` always.

Top module: `dma_burst_seq`

## Requirements
- R1: The channel with the lowest index that has units left is granted, channel 0 first. Arbitration happens again after every unit. The run ends when no channel has units left.
- R2: A run starts with exactly one idle cycle (`idle_cyc`=1, `bus_req`=0) before its first access, and it ends with exactly one idle cycle after its last unit.
- R3: When the granted channel differs from the last active channel, the burst flag is cleared before that unit's read. That read is therefore non-sequential (`bus_seq`=0), unless it is skipped.
- R4: An access carries `bus_seq`=0 while the burst flag is clear and `bus_seq`=1 once it is set. Any performed access whose address lies in 0x0800_0000..0x0DFF_FFFF sets the flag for all following accesses.
- R5: At the end of a run the burst flag is cleared and the last active channel becomes 0. The first access of the next run is therefore non-sequential.
- R6: A source or target address below 0x0200_0000 is never driven on the bus. An idle cycle takes the place of that access.
- R7: Word units (`cfg_word`=1) clear address bits 1:0 and step by 4. Halfword units clear bit 0 and step by 2.
- R8: Halfword read data bits 15:0 are copied into both 16-bit halves of the unit latch. The write data is the latch shifted right by 16 when target address bit 1 is set, and unshifted otherwise.
- R9: The step modes are 0 = increment, 1 = decrement, and 2 or 3 = fixed. Each address steps independently after every unit.
- R10: A channel's unit counter decrements by one per unit, and the channel stops requesting at zero. A load with a count of zero starts nothing. A load is accepted only in `ST_IDLE` and is ignored during a run.
- R11: After reset, `bus_req` and `idle_cyc` are 0 and no channel has units left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | NCH | Per-channel load strobe |
| cfg_src | input | NCH×32 | Source address to load |
| cfg_dst | input | NCH×32 | Target address to load |
| cfg_len | input | NCH×LEN_W | Unit count to load |
| cfg_word | input | NCH | Unit size: 1 = word, 0 = halfword |
| cfg_src_step | input | NCH×2 | Source step mode |
| cfg_dst_step | input | NCH×2 | Target step mode |
| bus_req | output | 1 | Access performed this cycle |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_word | output | 1 | Access size: 1 = word |
| bus_seq | output | 1 | 1 = sequential access |
| bus_addr | output | 32 | Aligned access address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, same cycle |
| idle_cyc | output | 1 | Idle cycle indication |

## Verification
A burst flag that is left set, or a stale last-channel register, shows as `bus_seq`=1 on the first access after a channel switch or at the start of a new run. It is visible on the very next bus cycle. A wrong grant or a wrong counter value shows as accesses to the wrong address, or as a missing or extra closing idle cycle. This is seen within one unit (two cycles). A latch or alignment fault appears on `bus_wdata` or `bus_addr` in the write cycle of the same unit.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int ADDR_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_READ,
        ST_WRITE,
        ST_TAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        STEP_INC = 2'd0,
        STEP_DEC = 2'd1,
        STEP_FIX = 2'd2,
        STEP_FX2 = 2'd3
    } step_t;

    // protected low region: never accessed
    function automatic logic is_protected(input logic [ADDR_W-1:0] a);
        return a < 32'h0200_0000;
    endfunction

    // program-memory window 0x0800_0000 .. 0x0DFF_FFFF
    function automatic logic is_program(input logic [ADDR_W-1:0] a);
        return (a >= 32'h0800_0000) && (a < 32'h0E00_0000);
    endfunction

    function automatic logic [ADDR_W-1:0] align_addr(input logic [ADDR_W-1:0] a,
                                                     input logic word);
        return word ? {a[ADDR_W-1:2], 2'b00} : {a[ADDR_W-1:1], 1'b0};
    endfunction

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                    input logic [1:0] mode,
                                                    input logic word);
        logic [ADDR_W-1:0] inc;
        inc = word ? ADDR_W'(4) : ADDR_W'(2);
        case (mode)
            STEP_INC: return a + inc;
            STEP_DEC: return a - inc;
            default:  return a;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan.sv
module dma_chan
    import dma_seq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] ld_src,
    input  logic [ADDR_W-1:0] ld_dst,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic              ld_word,
    input  logic [1:0]        ld_sstep,
    input  logic [1:0]        ld_dstep,
    input  logic              adv,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic              word_o,
    output logic              active_o,
    output logic              last_o
);

    logic [ADDR_W-1:0] src_q, dst_q;
    logic [LEN_W-1:0]  len_q;
    logic              word_q;
    logic [1:0]        sstep_q, dstep_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            dst_q   <= '0;
            len_q   <= '0;
            word_q  <= 1'b0;
            sstep_q <= 2'd0;
            dstep_q <= 2'd0;
        end else if (load_en) begin
            src_q   <= ld_src;
            dst_q   <= ld_dst;
            len_q   <= ld_len;
            word_q  <= ld_word;
            sstep_q <= ld_sstep;
            dstep_q <= ld_dstep;
        end else if (adv) begin
            src_q <= step_addr(src_o, sstep_q, word_q);
            dst_q <= step_addr(dst_o, dstep_q, word_q);
            len_q <= len_q - LEN_W'(1);
        end
    end

    assign src_o    = align_addr(src_q, word_q);
    assign dst_o    = align_addr(dst_q, word_q);
    assign word_o   = word_q;
    assign active_o = (len_q != '0);
    assign last_o   = (len_q == LEN_W'(1));

    // R10
    len_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_en) && len_q != $past(len_q)) |-> (len_q == $past(len_q) - LEN_W'(1)));

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic [NCH-1:0]  req,
    output logic            any,
    output logic [CH_W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx = CH_W'(i);
        end
    end

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
    import dma_seq_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int LEN_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCH-1:0]                cfg_start,
    input  logic [NCH-1:0][ADDR_W-1:0]    cfg_src,
    input  logic [NCH-1:0][ADDR_W-1:0]    cfg_dst,
    input  logic [NCH-1:0][LEN_W-1:0]     cfg_len,
    input  logic [NCH-1:0]                cfg_word,
    input  logic [NCH-1:0][1:0]           cfg_src_step,
    input  logic [NCH-1:0][1:0]           cfg_dst_step,
    output logic                          bus_req,
    output logic                          bus_write,
    output logic                          bus_word,
    output logic                          bus_seq,
    output logic [ADDR_W-1:0]             bus_addr,
    output logic [ADDR_W-1:0]             bus_wdata,
    input  logic [ADDR_W-1:0]             bus_rdata,
    output logic                          idle_cyc
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    seq_state_t        state_q, state_d;
    logic [CH_W-1:0]   gnt_q, last_q, pick;
    logic              burst_q, any_req;
    logic [ADDR_W-1:0] data_q;

    logic [ADDR_W-1:0] ch_src [NCH];
    logic [ADDR_W-1:0] ch_dst [NCH];
    logic [NCH-1:0]    ch_word, ch_act, ch_last, adv_vec, arb_req;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign adv_vec[i] = (state_q == ST_WRITE) && (gnt_q == CH_W'(i));
            dma_chan #(.LEN_W(LEN_W)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .load_en  (cfg_start[i] && state_q == ST_IDLE),
                .ld_src   (cfg_src[i]),
                .ld_dst   (cfg_dst[i]),
                .ld_len   (cfg_len[i]),
                .ld_word  (cfg_word[i]),
                .ld_sstep (cfg_src_step[i]),
                .ld_dstep (cfg_dst_step[i]),
                .adv      (adv_vec[i]),
                .src_o    (ch_src[i]),
                .dst_o    (ch_dst[i]),
                .word_o   (ch_word[i]),
                .active_o (ch_act[i]),
                .last_o   (ch_last[i])
            );
        end
    endgenerate

    // in the write cycle the granted channel may be finishing its last unit
    assign arb_req = ch_act & ~(adv_vec & ch_last);

    dma_prio_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
        .req (arb_req),
        .any (any_req),
        .idx (pick)
    );

    logic [ADDR_W-1:0] cur_src, cur_dst;
    logic              cur_word, src_skip, dst_skip, burst_eff;

    assign cur_src   = ch_src[gnt_q];
    assign cur_dst   = ch_dst[gnt_q];
    assign cur_word  = ch_word[gnt_q];
    assign src_skip  = is_protected(cur_src);
    assign dst_skip  = is_protected(cur_dst);
    assign burst_eff = (gnt_q == last_q) ? burst_q : 1'b0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (|ch_act) state_d = ST_LEAD;
            ST_LEAD:  state_d = any_req ? ST_READ : ST_TAIL;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: state_d = any_req ? ST_READ : ST_TAIL;
            ST_TAIL:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gnt_q   <= '0;
            last_q  <= '0;
            burst_q <= 1'b0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_READ) gnt_q <= pick;
            unique case (state_q)
                ST_READ: begin
                    last_q  <= gnt_q;
                    burst_q <= burst_eff | (!src_skip && is_program(cur_src));
                    if (!src_skip)
                        data_q <= cur_word ? bus_rdata : {bus_rdata[15:0], bus_rdata[15:0]};
                end
                ST_WRITE: burst_q <= burst_q | (!dst_skip && is_program(cur_dst));
                ST_TAIL: begin
                    burst_q <= 1'b0;
                    last_q  <= '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        bus_write = 1'b0;
        bus_word  = cur_word;
        bus_seq   = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        idle_cyc  = 1'b0;
        unique case (state_q)
            ST_LEAD, ST_TAIL: idle_cyc = 1'b1;
            ST_READ: begin
                if (src_skip) idle_cyc = 1'b1;
                else begin
                    bus_req  = 1'b1;
                    bus_addr = cur_src;
                    bus_seq  = burst_eff;
                end
            end
            ST_WRITE: begin
                if (dst_skip) idle_cyc = 1'b1;
                else begin
                    bus_req   = 1'b1;
                    bus_write = 1'b1;
                    bus_addr  = cur_dst;
                    bus_seq   = burst_q;
                    bus_wdata = cur_dst[1] ? (data_q >> 16) : data_q;
                end
            end
            default: ;
        endcase
    end

    // R6
    no_protected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr >= 32'h0200_0000));

    // R7
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_word) |-> (bus_addr[1:0] == 2'b00));

    // R7
    half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_word) |-> (bus_addr[0] == 1'b0));

    // R2
    idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && idle_cyc));

    // R5
    run_start_nonseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD) |=> !(bus_req && bus_seq));

    // R1
    grant_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |-> ch_act[gnt_q]);

endmodule

// File: tb/dma_burst_seq_tb.sv
module dma_burst_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int LEN_W = 16;
    localparam int MAXEV = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0]             cfg_start = '0;
    logic [NCH-1:0][31:0]       cfg_src = '0;
    logic [NCH-1:0][31:0]       cfg_dst = '0;
    logic [NCH-1:0][LEN_W-1:0]  cfg_len = '0;
    logic [NCH-1:0]             cfg_word = '0;
    logic [NCH-1:0][1:0]        cfg_src_step = '0;
    logic [NCH-1:0][1:0]        cfg_dst_step = '0;
    logic bus_req, bus_write, bus_word, bus_seq, idle_cyc;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h1234_5678;
    endfunction

    assign bus_rdata = mem_fn(bus_addr);

    dma_burst_seq #(.NCH(NCH), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_src(cfg_src),
        .cfg_dst(cfg_dst), .cfg_len(cfg_len), .cfg_word(cfg_word),
        .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step),
        .bus_req(bus_req), .bus_write(bus_write), .bus_word(bus_word),
        .bus_seq(bus_seq), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .idle_cyc(idle_cyc)
    );

    int n_checks = 0;
    int n_fail = 0;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // event kinds: 1 idle, 2 read, 3 write
    int          g_kind [MAXEV];
    logic [31:0] g_addr [MAXEV];
    logic        g_seq  [MAXEV];
    logic        g_word [MAXEV];
    logic [31:0] g_wd   [MAXEV];
    int          n_got = 0;
    int          e_kind [MAXEV];
    logic [31:0] e_addr [MAXEV];
    logic        e_seq  [MAXEV];
    logic        e_word [MAXEV];
    logic [31:0] e_wd   [MAXEV];
    int          n_exp = 0;

    always @(negedge clk) begin
        if (rst_n && (idle_cyc || bus_req) && n_got < MAXEV) begin
            g_kind[n_got] = idle_cyc ? 1 : (bus_write ? 3 : 2);
            g_addr[n_got] = idle_cyc ? 32'h0 : bus_addr;
            g_seq[n_got]  = idle_cyc ? 1'b0 : bus_seq;
            g_word[n_got] = idle_cyc ? 1'b0 : bus_word;
            g_wd[n_got]   = (bus_req && bus_write) ? bus_wdata : 32'h0;
            n_got++;
        end
    end

    // requirement-level model state
    logic [31:0] m_src [NCH];
    logic [31:0] m_dst [NCH];
    int          m_len [NCH];
    logic        m_word [NCH];
    logic [1:0]  m_ss [NCH];
    logic [1:0]  m_ds [NCH];
    logic        m_burst = 1'b0;
    int          m_last = 0;
    logic [31:0] m_latch = '0;

    task automatic push(input int k, input logic [31:0] a, input logic s,
                        input logic w, input logic [31:0] d);
        if (n_exp < MAXEV) begin
            e_kind[n_exp] = k; e_addr[n_exp] = a; e_seq[n_exp] = s;
            e_word[n_exp] = w; e_wd[n_exp] = d;
            n_exp++;
        end
    endtask

    function automatic logic [31:0] m_align(input logic [31:0] a, input logic w);
        return w ? {a[31:2], 2'b00} : {a[31:1], 1'b0};
    endfunction

    function automatic logic [31:0] m_step(input logic [31:0] a, input logic [1:0] m,
                                           input logic w);
        if (m == 2'd0) return a + (w ? 4 : 2);
        if (m == 2'd1) return a - (w ? 4 : 2);
        return a;
    endfunction

    function automatic logic m_prog(input logic [31:0] a);
        return a >= 32'h0800_0000 && a < 32'h0E00_0000;
    endfunction

    task automatic model_run();
        int ch;
        logic [31:0] sa, da, r;
        n_exp = 0;
        ch = -1;
        for (int i = NCH - 1; i >= 0; i--) if (m_len[i] != 0) ch = i;
        if (ch < 0) return;
        push(1, 0, 0, 0, 0);
        while (ch >= 0) begin
            if (ch != m_last) begin m_burst = 1'b0; m_last = ch; end
            sa = m_align(m_src[ch], m_word[ch]);
            da = m_align(m_dst[ch], m_word[ch]);
            if (sa < 32'h0200_0000) push(1, 0, 0, 0, 0);
            else begin
                push(2, sa, m_burst, m_word[ch], 0);
                m_burst = m_burst | m_prog(sa);
                r = mem_fn(sa);
                m_latch = m_word[ch] ? r : {r[15:0], r[15:0]};
            end
            if (da < 32'h0200_0000) push(1, 0, 0, 0, 0);
            else begin
                push(3, da, m_burst, m_word[ch], da[1] ? (m_latch >> 16) : m_latch);
                m_burst = m_burst | m_prog(da);
            end
            m_src[ch] = m_step(sa, m_ss[ch], m_word[ch]);
            m_dst[ch] = m_step(da, m_ds[ch], m_word[ch]);
            m_len[ch]--;
            ch = -1;
            for (int i = NCH - 1; i >= 0; i--) if (m_len[i] != 0) ch = i;
        end
        push(1, 0, 0, 0, 0);
        m_burst = 1'b0;
        m_last = 0;
    endtask

    task automatic set_cfg(input int c, input logic [31:0] s, input logic [31:0] d,
                           input logic w, input logic [1:0] ss, input logic [1:0] ds,
                           input int len, input logic accept);
        cfg_src[c] = s; cfg_dst[c] = d; cfg_word[c] = w;
        cfg_src_step[c] = ss; cfg_dst_step[c] = ds; cfg_len[c] = LEN_W'(len);
        cfg_start[c] = 1'b1;
        if (accept) begin
            m_src[c] = s; m_dst[c] = d; m_word[c] = w;
            m_ss[c] = ss; m_ds[c] = ds; m_len[c] = len;
        end
    endtask

    task automatic pulse();
        @(posedge clk); #1;
        cfg_start = '0;
    endtask

    task automatic compare(input string req);
        chk(n_got == n_exp, req, "event count", 32'(n_got), 32'(n_exp));
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            chk(g_kind[i] == e_kind[i], req, $sformatf("ev%0d kind", i), 32'(g_kind[i]), 32'(e_kind[i]));
            chk(g_addr[i] == e_addr[i], req, $sformatf("ev%0d addr", i), g_addr[i], e_addr[i]);
            chk(g_seq[i] == e_seq[i], req, $sformatf("ev%0d seq", i), 32'(g_seq[i]), 32'(e_seq[i]));
            chk(g_word[i] == e_word[i], req, $sformatf("ev%0d size", i), 32'(g_word[i]), 32'(e_word[i]));
            chk(g_wd[i] == e_wd[i], req, $sformatf("ev%0d wdata", i), g_wd[i], e_wd[i]);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    typedef struct packed {
        logic [1:0]  ch;
        logic [31:0] src;
        logic [31:0] dst;
        logic        word;
        logic [1:0]  ss;
        logic [1:0]  ds;
        logic [7:0]  len;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 32'h0300_0000, 32'h0300_1002, 1'b0, 2'd0, 2'd0, 8'd3}, // R8 R7 halfword, shifted write
        '{2'd1, 32'h0800_0010, 32'h0300_0100, 1'b1, 2'd0, 2'd0, 8'd3}, // R4 program source
        '{2'd2, 32'h0300_0203, 32'h0600_0007, 1'b1, 2'd1, 2'd2, 8'd2}, // R7 R9 dec/fixed
        '{2'd3, 32'h0000_1000, 32'h0200_0000, 1'b0, 2'd2, 2'd0, 8'd2}, // R6 protected source
        '{2'd0, 32'h0200_0040, 32'h0000_0010, 1'b1, 2'd0, 2'd0, 8'd1}, // R6 protected target
        '{2'd1, 32'h0300_0000, 32'h0900_0000, 1'b0, 2'd3, 2'd1, 8'd3}  // R4 R9 program target
    };

    localparam int WATCHDOG = 100000;
    int cyc = 0;
    logic done = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <%0d", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_src[i] = '0; m_dst[i] = '0; m_len[i] = 0;
            m_word[i] = 1'b0; m_ss[i] = 2'd0; m_ds[i] = 2'd0;
        end
        wait_cycles(3);
        // R11 reset state
        chk(bus_req == 1'b0, "R11", "bus_req in reset", 32'(bus_req), 0);
        chk(idle_cyc == 1'b0, "R11", "idle_cyc in reset", 32'(idle_cyc), 0);
        rst_n = 1'b1;
        wait_cycles(3);
        chk(bus_req == 1'b0 && idle_cyc == 1'b0, "R11", "quiet after reset",
            32'({bus_req, idle_cyc}), 0);

        // table walk: R1 R2 R4 R6 R7 R8 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            n_got = 0;
            set_cfg(int'(VECS[v].ch), VECS[v].src, VECS[v].dst, VECS[v].word,
                    VECS[v].ss, VECS[v].ds, int'(VECS[v].len), 1'b1);
            model_run();
            pulse();
            wait_cycles(2 * int'(VECS[v].len) + 8);
            compare($sformatf("R2 R4 R6 R7 R8 R9 vec%0d", v));
        end

        // R1 R3: two channels together, channel 0 first, switch clears burst
        n_got = 0;
        set_cfg(1, 32'h0300_0400, 32'h0300_0500, 1'b1, 2'd0, 2'd0, 2, 1'b1);
        set_cfg(0, 32'h0800_0100, 32'h0300_0600, 1'b1, 2'd0, 2'd0, 2, 1'b1);
        model_run();
        pulse();
        wait_cycles(16);
        compare("R1 R3");
        chk(n_got > 5 && g_addr[5] == 32'h0300_0400 && g_seq[5] == 1'b0, "R3",
            "first read after switch", {31'(g_addr[5]), g_seq[5]}, {31'h0300_0400, 1'b0});

        // R5: two runs on channel 0 from program memory; second starts non-sequential
        n_got = 0;
        set_cfg(0, 32'h0800_0200, 32'h0300_0700, 1'b0, 2'd0, 2'd0, 2, 1'b1);
        model_run();
        pulse();
        wait_cycles(12);
        compare("R5 run A");
        n_got = 0;
        set_cfg(0, 32'h0800_0300, 32'h0300_0800, 1'b0, 2'd0, 2'd0, 1, 1'b1);
        model_run();
        pulse();
        wait_cycles(10);
        compare("R5 run B");
        chk(n_got > 1 && g_kind[1] == 2 && g_seq[1] == 1'b0, "R5",
            "first access of new run", 32'(g_seq[1]), 0);

        // R10: load during a run is ignored
        n_got = 0;
        set_cfg(0, 32'h0300_0900, 32'h0300_0A00, 1'b1, 2'd0, 2'd0, 3, 1'b1);
        model_run();
        pulse();
        wait_cycles(3);
        set_cfg(2, 32'h0300_0B00, 32'h0300_0C00, 1'b1, 2'd0, 2'd0, 2, 1'b0);
        pulse();
        wait_cycles(20);
        compare("R10 load during run");

        // R10: zero-count load starts nothing
        n_got = 0;
        set_cfg(3, 32'h0300_0D00, 32'h0300_0E00, 1'b1, 2'd0, 2'd0, 0, 1'b1);
        model_run();
        pulse();
        wait_cycles(8);
        chk(n_got == 0, "R10", "zero count activity", 32'(n_got), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule